// File: doc/BRIEF.md
# Per-CPU Highest-Priority Pending Interrupt Selector

This block looks at a bank of interrupt sources on behalf of each CPU and finds the most urgent source that is both enabled and pending for that CPU. The winner is then tested against two per-CPU thresholds. The priority mask decides whether the winner is published as the CPU's pending interrupt ID. A strict comparison against the CPU's running priority decides whether the CPU's interrupt request line is driven high. Because the second test is strict, a new interrupt can preempt a running one only when it is more urgent than the running one.

The published ID is meant for a neighbouring acknowledge block. The request line goes to the processor. All configuration arrives as flat input vectors: enables, pending bits, the two priority tables, the global enable, the CPU interface enables, the masks and the running priorities. The block holds none of that state itself. A comparison tree picks the winner in the same cycle. Both outputs are registered, so they follow their inputs one clock later.

Top module: `irq_pick_top`

## Requirements
- R1: Among the sources that are enabled and pending for a CPU, the one with the numerically smallest 8-bit priority is selected, because a smaller value means more urgent.
- R2: When two candidates have equal priority, the candidate with the lower source index wins.
- R3: While `dist_en` is 0, every `irq_req` bit is 0 and every `pend_id` field is 1023.
- R4: While bit c of `cpu_if_en` is 0, `irq_req[c]` is 0 and the `pend_id` field of CPU c is 1023. Other CPUs are unaffected.
- R5: The winner's index is published in the 10-bit `pend_id` field of CPU c (bits c*10 and up) only if its priority is less than or equal to that CPU's 8-bit mask. Otherwise the field reads 1023. Equality counts as unmasked.
- R6: `irq_req[c]` is 1 only when a winner is published and its priority is strictly less than that CPU's 9-bit running priority. With equal values the ID is still published but the line stays low.
- R7: A running priority of 0x100 marks an idle CPU. With the mask at 0xFF, even a priority of 0xFF raises the request.
- R8: Sources 0..31 take their priority from a per-CPU bank, at byte (c*32+s) of `prio_banked`. Sources 32..63 share one priority, at byte (s-32) of `prio_common`.
- R9: Both outputs are registered. A change at the inputs appears at the outputs after exactly one rising clock edge, and not before it.
- R10: While reset is asserted, every request line is 0 and every published ID is 1023.
- R11: A source whose enable bit is 0 is never selected, and a source is only selected for CPUs whose pending bit (bit c*64+s of `src_pend`) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global forwarding enable |
| cpu_if_en | input | 2 | Per-CPU interface enable |
| src_en | input | 64 | Per-source enable |
| src_pend | input | 128 | Pending bits, CPU-major (bit c*64+s) |
| prio_banked | input | 512 | Per-CPU priorities of sources 0..31, byte c*32+s |
| prio_common | input | 256 | Shared priorities of sources 32..63, byte s-32 |
| prio_mask | input | 16 | Per-CPU priority mask, byte c |
| run_prio | input | 18 | Per-CPU running priority, 9 bits each, 0x100 when idle |
| irq_req | output | 2 | Per-CPU interrupt request line |
| pend_id | output | 20 | Per-CPU published pending ID, 10 bits each, 1023 when none |

## Verification
The assertions check, on every cycle, that a published ID belongs to a source that was enabled and pending in the previous cycle. They also check that no other candidate from that cycle was more urgent or equally urgent with a lower index, that the ID passes the mask, that a raised line passed the strict running-priority test, and that either disable forces the idle outputs. These checks can only see what the design chose. The bench scenarios are needed to show that the correct ID appears when it should. They cover exact boundaries at mask and running priority, the bank switch at source 32, one CPU differing from the other, the idle value 0x100 and the one-edge latency. Those cases are stepped through with literal expected values, and a seeded random sweep is compared against a bench model.

// File: rtl/ips_pkg.sv
package ips_pkg;
  localparam int IPS_NUM_SRC  = 64;
  localparam int IPS_NUM_CPU  = 2;
  localparam int IPS_NUM_PRIV = 32;
  localparam int IPS_PW       = 8;
  localparam int IPS_ID_W     = 10;
  localparam logic [IPS_ID_W-1:0] IPS_ID_NONE = 10'd1023;
endpackage

// File: rtl/ips_prio_route.sv
module ips_prio_route #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_PRIV = 32,
  parameter int PW       = 8
) (
  input  logic [NUM_PRIV*PW-1:0]           banked_i,
  input  logic [(NUM_SRC-NUM_PRIV)*PW-1:0] common_i,
  output logic [NUM_SRC*PW-1:0]            prio_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < NUM_PRIV) begin : g_bank
      assign prio_o[s*PW +: PW] = banked_i[s*PW +: PW];
    end else begin : g_shared
      assign prio_o[s*PW +: PW] = common_i[(s-NUM_PRIV)*PW +: PW];
    end
  end
endmodule

// File: rtl/ips_best_tree.sv
module ips_best_tree #(
  parameter int NUM_SRC = 64,
  parameter int PW      = 8,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int LEAVES = 1 << SRC_W,
  localparam int NODES  = 2*LEAVES - 1
) (
  input  logic [NUM_SRC-1:0]    en_i,
  input  logic [NUM_SRC-1:0]    pend_i,
  input  logic [NUM_SRC*PW-1:0] prio_i,
  output logic                  best_v_o,
  output logic [PW-1:0]         best_p_o,
  output logic [SRC_W-1:0]      best_i_o
);
  logic             lv [LEAVES];
  logic [PW-1:0]    lp [LEAVES];
  logic [SRC_W-1:0] li [LEAVES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NUM_SRC) begin : g_real
      assign lv[j] = en_i[j] & pend_i[j];
      assign lp[j] = prio_i[j*PW +: PW];
    end else begin : g_pad
      assign lv[j] = 1'b0;
      assign lp[j] = '1;
    end
    assign li[j] = SRC_W'(j);
  end

  logic             nv [NODES];
  logic [PW-1:0]    np [NODES];
  logic [SRC_W-1:0] ni [NODES];

  // Reduce pairwise from the leaves up; the right child replaces the left
  // only when strictly more urgent, so the lower index keeps a tie.
  always_comb begin
    for (int j = 0; j < LEAVES; j++) begin
      nv[LEAVES-1+j] = lv[j];
      np[LEAVES-1+j] = lp[j];
      ni[LEAVES-1+j] = li[j];
    end
    for (int k = LEAVES-2; k >= 0; k--) begin
      if (nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] < np[2*k+1]))) begin
        nv[k] = 1'b1;
        np[k] = np[2*k+2];
        ni[k] = ni[2*k+2];
      end else begin
        nv[k] = nv[2*k+1];
        np[k] = np[2*k+1];
        ni[k] = ni[2*k+1];
      end
    end
  end

  assign best_v_o = nv[0];
  assign best_p_o = np[0];
  assign best_i_o = ni[0];
endmodule

// File: rtl/ips_cpu_gate.sv
module ips_cpu_gate
  import ips_pkg::*;
#(
  parameter int PW    = 8,
  parameter int SRC_W = 6,
  parameter int ID_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en_i,
  input  logic             if_en_i,
  input  logic             cand_v_i,
  input  logic [PW-1:0]    cand_p_i,
  input  logic [SRC_W-1:0] cand_i_i,
  input  logic [PW-1:0]    mask_i,
  input  logic [PW:0]      run_i,
  output logic             req_o,
  output logic [ID_W-1:0]  id_o
);
  localparam logic [ID_W-1:0] NONE = '1;

  logic            show_c;
  logic            req_d, req_q;
  logic [ID_W-1:0] id_d, id_q;
  logic            upd_en;

  always_comb begin
    show_c = glb_en_i && if_en_i && cand_v_i && (cand_p_i <= mask_i);
    id_d   = show_c ? ID_W'(cand_i_i) : NONE;
    req_d  = show_c && ({1'b0, cand_p_i} < run_i);
    upd_en = (id_d != id_q) || (req_d != req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= NONE;
      req_q <= 1'b0;
    end else if (upd_en) begin
      id_q  <= id_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
  assign id_o  = id_q;
endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
  import ips_pkg::*;
#(
  parameter int NUM_SRC  = IPS_NUM_SRC,
  parameter int NUM_CPU  = IPS_NUM_CPU,
  parameter int NUM_PRIV = IPS_NUM_PRIV,
  parameter int PW       = IPS_PW,
  parameter int ID_W     = IPS_ID_W,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int RW      = PW + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            dist_en,
  input  logic [NUM_CPU-1:0]              cpu_if_en,
  input  logic [NUM_SRC-1:0]              src_en,
  input  logic [NUM_CPU*NUM_SRC-1:0]      src_pend,
  input  logic [NUM_CPU*NUM_PRIV*PW-1:0]  prio_banked,
  input  logic [(NUM_SRC-NUM_PRIV)*PW-1:0] prio_common,
  input  logic [NUM_CPU*PW-1:0]           prio_mask,
  input  logic [NUM_CPU*RW-1:0]           run_prio,
  output logic [NUM_CPU-1:0]              irq_req,
  output logic [NUM_CPU*ID_W-1:0]         pend_id
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC*PW-1:0] prio_vec;
    logic                  best_v;
    logic [PW-1:0]         best_p;
    logic [SRC_W-1:0]      best_i;

    ips_prio_route #(.NUM_SRC(NUM_SRC), .NUM_PRIV(NUM_PRIV), .PW(PW)) u_route (
      .banked_i (prio_banked[c*NUM_PRIV*PW +: NUM_PRIV*PW]),
      .common_i (prio_common),
      .prio_o   (prio_vec)
    );

    ips_best_tree #(.NUM_SRC(NUM_SRC), .PW(PW)) u_tree (
      .en_i     (src_en),
      .pend_i   (src_pend[c*NUM_SRC +: NUM_SRC]),
      .prio_i   (prio_vec),
      .best_v_o (best_v),
      .best_p_o (best_p),
      .best_i_o (best_i)
    );

    ips_cpu_gate #(.PW(PW), .SRC_W(SRC_W), .ID_W(ID_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_en_i (dist_en),
      .if_en_i  (cpu_if_en[c]),
      .cand_v_i (best_v),
      .cand_p_i (best_p),
      .cand_i_i (best_i),
      .mask_i   (prio_mask[c*PW +: PW]),
      .run_i    (run_prio[c*RW +: RW]),
      .req_o    (irq_req[c]),
      .id_o     (pend_id[c*ID_W +: ID_W])
    );
  end
endmodule

// File: rtl/ips_checker.sv
module ips_checker #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 32,
  parameter int PW       = 8,
  parameter int ID_W     = 10,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int RW      = PW + 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             dist_en,
  input logic [NUM_CPU-1:0]               cpu_if_en,
  input logic [NUM_SRC-1:0]               src_en,
  input logic [NUM_CPU*NUM_SRC-1:0]       src_pend,
  input logic [NUM_CPU*NUM_PRIV*PW-1:0]   prio_banked,
  input logic [(NUM_SRC-NUM_PRIV)*PW-1:0] prio_common,
  input logic [NUM_CPU*PW-1:0]            prio_mask,
  input logic [NUM_CPU*RW-1:0]            run_prio,
  input logic [NUM_CPU-1:0]               irq_req,
  input logic [NUM_CPU*ID_W-1:0]          pend_id
);
  localparam logic [ID_W-1:0] NONE = '1;

  logic                            h_ok, h_dist;
  logic [NUM_CPU-1:0]              h_ifen;
  logic [NUM_SRC-1:0]              h_en;
  logic [NUM_CPU*NUM_SRC-1:0]      h_pend;
  logic [NUM_CPU*NUM_PRIV*PW-1:0]  h_bank;
  logic [(NUM_SRC-NUM_PRIV)*PW-1:0] h_comm;
  logic [NUM_CPU*PW-1:0]           h_mask;
  logic [NUM_CPU*RW-1:0]           h_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ok <= 1'b0; h_dist <= 1'b0; h_ifen <= '0; h_en <= '0; h_pend <= '0;
      h_bank <= '0; h_comm <= '0; h_mask <= '0; h_run <= '0;
    end else begin
      h_ok <= 1'b1; h_dist <= dist_en; h_ifen <= cpu_if_en; h_en <= src_en;
      h_pend <= src_pend; h_bank <= prio_banked; h_comm <= prio_common;
      h_mask <= prio_mask; h_run <= run_prio;
    end
  end

  function automatic logic [PW-1:0] h_prio(int c, int s);
    if (s < NUM_PRIV) return h_bank[(c*NUM_PRIV+s)*PW +: PW];
    else              return h_comm[(s-NUM_PRIV)*PW +: PW];
  endfunction

  logic [NUM_CPU-1:0] none_c, cand_ok, beaten, mask_ok, run_ok;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      logic [ID_W-1:0] id;
      int              ix;
      logic [PW-1:0]   pid;
      id = pend_id[c*ID_W +: ID_W];
      none_c[c] = (id == NONE);
      ix = (int'(id) < NUM_SRC) ? int'(id) : 0;
      pid = h_prio(c, ix);
      cand_ok[c] = (int'(id) < NUM_SRC) && h_en[ix] && h_pend[c*NUM_SRC+ix];
      mask_ok[c] = pid <= h_mask[c*PW +: PW];
      run_ok[c]  = {1'b0, pid} < h_run[c*RW +: RW];
      beaten[c]  = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (h_en[s] && h_pend[c*NUM_SRC+s] &&
            ((h_prio(c, s) < pid) || ((h_prio(c, s) == pid) && (s < ix))))
          beaten[c] = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r10: assert (irq_req == '0 && (&pend_id))
        else $error("outputs not idle in reset");
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_a
    p_glboff_r3: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok && !h_dist |-> !irq_req[c] && none_c[c]);
    p_ifoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok && !h_ifen[c] |-> !irq_req[c] && none_c[c]);
    p_cand_r11: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok && !none_c[c] |-> cand_ok[c]);
    p_best_r1: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok && !none_c[c] |-> !beaten[c]);
    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok && !none_c[c] |-> mask_ok[c]);
    p_reqid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> !none_c[c]);
    p_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok && irq_req[c] |-> run_ok[c]);
  end
endmodule

bind irq_pick_top ips_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PRIV(NUM_PRIV), .PW(PW), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
  .src_en(src_en), .src_pend(src_pend), .prio_banked(prio_banked),
  .prio_common(prio_common), .prio_mask(prio_mask), .run_prio(run_prio),
  .irq_req(irq_req), .pend_id(pend_id)
);

// File: tb/tb_irq_pick_top.sv
module tb_irq_pick_top;
  localparam int NS = 64, NC = 2, NP = 32, PW = 8, IW = 10, RW = 9;
  localparam logic [IW-1:0] NONE = 10'd1023;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic dist_en;
  logic [NC-1:0] cpu_if_en;
  logic [NS-1:0] src_en;
  logic [NC*NS-1:0] src_pend;
  logic [NC*NP*PW-1:0] prio_banked;
  logic [(NS-NP)*PW-1:0] prio_common;
  logic [NC*PW-1:0] prio_mask;
  logic [NC*RW-1:0] run_prio;
  logic [NC-1:0] irq_req;
  logic [NC*IW-1:0] pend_id;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_pick_top dut (.*);

  task automatic chk(int c, logic er, logic [IW-1:0] ei, string tag);
    logic ar; logic [IW-1:0] ai;
    ar = irq_req[c]; ai = pend_id[c*IW +: IW];
    n_tests++;
    if (ar !== er || ai !== ei) begin
      n_fail++;
      $display("FAIL %s cpu%0d: req=%0b id=%0d expected req=%0b id=%0d", tag, c, ar, ai, er, ei);
    end
  endtask

  task automatic set_bank(int c, int s, int p); prio_banked[(c*NP+s)*PW +: PW] = PW'(p); endtask
  task automatic set_comm(int s, int p); prio_common[(s-NP)*PW +: PW] = PW'(p); endtask
  task automatic set_pend(int c, int s, logic v); src_pend[c*NS+s] = v; endtask
  task automatic step(); @(negedge clk); endtask

  function automatic logic [IW:0] model(int c);
    int bp = 256, bi = -1;
    for (int s = 0; s < NS; s++) begin
      int p;
      p = (s < NP) ? int'(prio_banked[(c*NP+s)*PW +: PW]) : int'(prio_common[(s-NP)*PW +: PW]);
      if (src_en[s] && src_pend[c*NS+s] && p < bp) begin bp = p; bi = s; end
    end
    if (!dist_en || !cpu_if_en[c] || bi < 0 || bp > int'(prio_mask[c*PW +: PW]))
      return {1'b0, NONE};
    return {(bp < int'(run_prio[c*RW +: RW])), IW'(bi)};
  endfunction

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    dist_en = 1'b1; cpu_if_en = '1; src_en = '0; src_pend = '0;
    prio_banked = '0; prio_common = '0;
    prio_mask = {NC{8'hF0}}; run_prio = {NC{9'h100}};
    #5 rst_n = 1'b0;
    step();
    chk(0, 1'b0, NONE, "R10 reset"); chk(1, 1'b0, NONE, "R10 reset");
    for (int s = 0; s < NS; s++) begin
      if (s < NP) begin set_bank(0, s, 8'h80); set_bank(1, s, 8'h80); end else set_comm(s, 8'h80);
    end
    src_en = '1;
    step(); rst_n = 1'b1;
    step();
    chk(0, 1'b0, NONE, "R10 nothing pending"); chk(1, 1'b0, NONE, "R10 nothing pending");

    // R1 most urgent wins
    set_comm(40, 8'h30); set_bank(0, 5, 8'h50);
    set_pend(0, 40, 1); set_pend(0, 5, 1);
    step(); step();
    chk(0, 1'b1, 10'd40, "R1 smaller value wins");
    chk(1, 1'b0, NONE, "R11 other cpu not pending");

    // R2 ties keep the lower index
    set_comm(45, 8'h30); set_pend(0, 45, 1);
    step(); step();
    chk(0, 1'b1, 10'd40, "R2 tie 40 vs 45");
    set_bank(0, 3, 8'h30); set_pend(0, 3, 1);
    step(); step();
    chk(0, 1'b1, 10'd3, "R2 tie 3 vs 40");

    // R8 banked vs shared
    src_pend = '0;
    set_bank(0, 7, 8'h10); set_bank(1, 7, 8'h90); set_comm(50, 8'h40);
    set_pend(0, 7, 1); set_pend(1, 7, 1); set_pend(0, 50, 1); set_pend(1, 50, 1);
    step(); step();
    chk(0, 1'b1, 10'd7, "R8 banked cpu0"); chk(1, 1'b1, 10'd50, "R8 shared cpu1");

    // R5 mask boundary (cpu1 best is 0x40)
    prio_mask[1*PW +: PW] = 8'h40;
    step(); step();
    chk(1, 1'b1, 10'd50, "R5 equal to mask");
    prio_mask[1*PW +: PW] = 8'h3F;
    step(); step();
    chk(1, 1'b0, NONE, "R5 above mask");
    prio_mask[1*PW +: PW] = 8'hF0;

    // R6 strict running-priority test
    run_prio[1*RW +: RW] = 9'h040;
    step(); step();
    chk(1, 1'b0, 10'd50, "R6 equal running prio");
    run_prio[1*RW +: RW] = 9'h041;
    step(); step();
    chk(1, 1'b1, 10'd50, "R6 below running prio");
    run_prio[1*RW +: RW] = 9'h100;

    // R7 idle lets 0xFF through
    src_pend = '0; set_comm(60, 8'hFF); set_pend(0, 60, 1);
    prio_mask[0 +: PW] = 8'hFF;
    step(); step();
    chk(0, 1'b1, 10'd60, "R7 idle with 0xFF");
    prio_mask[0 +: PW] = 8'hF0;

    // R11 disabled source ignored
    set_pend(0, 60, 0); set_pend(0, 20, 1); set_bank(0, 20, 8'h20); set_pend(0, 21, 1);
    src_en[20] = 1'b0;
    step(); step();
    chk(0, 1'b1, 10'd21, "R11 disabled source skipped");
    src_en[20] = 1'b1;

    // R9 latency: unchanged before the edge, updated after it
    step();
    chk(0, 1'b1, 10'd20, "R9 settled");
    set_bank(0, 9, 8'h01); set_pend(0, 9, 1);
    #1 chk(0, 1'b1, 10'd20, "R9 before edge");
    step();
    chk(0, 1'b1, 10'd9, "R9 after one edge");

    // R4 per-CPU interface off, R3 global off
    set_pend(1, 9, 1);
    cpu_if_en = 2'b01;
    step(); step();
    chk(0, 1'b1, 10'd9, "R4 cpu0 unaffected"); chk(1, 1'b0, NONE, "R4 cpu1 off");
    cpu_if_en = 2'b11; dist_en = 1'b0;
    step(); step();
    chk(0, 1'b0, NONE, "R3 global off"); chk(1, 1'b0, NONE, "R3 global off");
    dist_en = 1'b1;

    // random sweep against the bench model (R1 R2 R5 R6 R8 R11)
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      logic [IW:0] e0, e1;
      for (int s = 0; s < NS; s++) begin
        src_en[s] = ($urandom % 8) != 0;
        for (int c = 0; c < NC; c++) set_pend(c, s, ($urandom % 6) == 0);
        if (s < NP) begin
          set_bank(0, s, $urandom % 16 * 16); set_bank(1, s, $urandom % 16 * 16);
        end else set_comm(s, $urandom % 16 * 16);
      end
      for (int c = 0; c < NC; c++) begin
        prio_mask[c*PW +: PW] = PW'($urandom % 256);
        run_prio[c*RW +: RW] = (($urandom % 4) == 0) ? 9'h100 : RW'($urandom % 256);
      end
      dist_en = ($urandom % 10) != 0;
      cpu_if_en = (($urandom % 5) == 0) ? NC'($urandom) : '1;
      e0 = model(0); e1 = model(1);
      step(); step();
      chk(0, e0[IW], e0[IW-1:0], "R1 R2 R5 R6 R8 R11 random");
      chk(1, e1[IW], e1[IW-1:0], "R1 R2 R5 R6 R8 R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule